// File: doc/BRIEF.md
# Shared Mailbox with Ownership Handoff

This block is a small shared mailbox that sits between a requesting function and a responding function. It holds eight 32-bit words and one ownership flag. While the requester owns the mailbox it fills the words over a plain register write port. Its write to the last word passes ownership to the responder, and the responder receives a one-cycle request pulse.

The responder may then rewrite any word. It returns the mailbox with a one-cycle release strobe, which loads its response word into the last word on the same clock edge. Bit 31 of the last word always shows who owns the mailbox.

A separate function-reset input puts the mailbox into a reset-read state, in which every word reads as all ones on both sides. When that input drops, the mailbox starts over empty and owned by the requester. Neither side interprets the payload.

Top module: `mbox_aperture`

## Requirements
- R1: After the block reset (`rst_n` low at a clock edge), every word reads 0x00000000 on both read ports, `pf_owns` is 0 and `req_valid` is 0.
- R2: While the requester owns the mailbox and `fn_rst` is low, a requester write to word k (k from 0 to 6) stores the data, and both read ports return it from the next cycle.
- R3: While the requester owns the mailbox, a requester write to word 7 hands ownership to the responder on the next edge, even when no other word was written before it. After that edge, bit 31 of word 7 reads 1 and bits 30:0 read the written bits 30:0.
- R4: `req_valid` is high for exactly one cycle, and that cycle is the first cycle in which `pf_owns` is 1.
- R5: Requester writes are ignored while the responder owns the mailbox. This holds for every word, word 7 included: no ownership change, no new pulse.
- R6: Responder writes are ignored while the requester owns the mailbox. They are stored while the responder owns it.
- R7: A `pf_release` while the responder owns the mailbox returns ownership to the requester on the next edge. On the same edge, word 7 bits 30:0 take `pf_resp_word` bits 30:0, and bit 31 then reads 0. A `pf_release` while the requester owns the mailbox has no effect.
- R8: While `fn_rst` is high, every word reads 0xFFFFFFFF on both read ports and writes from either side are ignored.
- R9: Once `fn_rst` drops, all words read 0 and the requester owns the mailbox.
- R10: When the responder raises `pf_release` and also writes word 7 in the same cycle, the release and its response word take effect and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| fn_rst | input | 1 | Requester function reset; forces the reset-read state |
| vf_wr_en | input | 1 | Requester write strobe |
| vf_wr_addr | input | 3 | Requester write word index |
| vf_wr_data | input | 32 | Requester write data |
| vf_rd_addr | input | 3 | Requester read word index |
| vf_rd_data | output | 32 | Requester read data (combinational) |
| pf_wr_en | input | 1 | Responder write strobe |
| pf_wr_addr | input | 3 | Responder write word index |
| pf_wr_data | input | 32 | Responder write data |
| pf_release | input | 1 | Responder release strobe |
| pf_resp_word | input | 32 | Response word loaded into word 7 on release |
| pf_rd_addr | input | 3 | Responder read word index |
| pf_rd_data | output | 32 | Responder read data (combinational) |
| req_valid | output | 1 | One-cycle request pulse to the responder |
| pf_owns | output | 1 | High while the responder owns the mailbox |

## Verification
A wrong ownership flag shows up on the next read of word 7 bit 31 and on `pf_owns`, one cycle after the write or release that should have moved it. The same fault appears as a write that lands, or is dropped, when it should have done the opposite. A stuck or doubled request pulse is visible at `req_valid` in the handoff cycle or the cycle after it. A word left uncleared after a function reset shows up on the first read once `fn_rst` drops. Each check therefore samples the ports one cycle after the edge that should change them.

// File: rtl/mbox_pkg.sv
// Package: shared types and helpers for the mailbox block.
// Assumes: one owner flag, one bit wide, 0 meaning the requester side.
package mbox_pkg;

    typedef enum logic {
        OWN_REQ = 1'b0,
        OWN_RSP = 1'b1
    } owner_e;

    // Returns 1 when the index names the final word of the mailbox.
    function automatic logic is_last(input int unsigned idx, input int unsigned words);
        return idx == (words - 1);
    endfunction

endpackage

// File: rtl/mbox_owner.sv
// Module: ownership control for the mailbox.
// Decides which side may write, moves ownership on the last-word write and
// on release, and produces the registered one-cycle request pulse.
// Assumes: fn_rst acts as a synchronous hold-in-reset for the whole state.
module mbox_owner
    import mbox_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fn_rst,
    input  logic   vf_wr_en,
    input  logic   vf_wr_last,
    input  logic   pf_wr_en,
    input  logic   pf_release,
    output owner_e owner,
    output logic   vf_accept,
    output logic   pf_accept,
    output logic   rel_take,
    output logic   req_pulse
);

    owner_e owner_q;
    logic   req_q;
    logic   handoff;

    // Gate each side's strobes by ownership and function reset.
    always_comb begin
        vf_accept = vf_wr_en   && !fn_rst && (owner_q == OWN_REQ);
        pf_accept = pf_wr_en   && !fn_rst && (owner_q == OWN_RSP);
        rel_take  = pf_release && !fn_rst && (owner_q == OWN_RSP);
        handoff   = vf_accept  && vf_wr_last;
    end

    // Ownership flag and request pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n || fn_rst) begin
            owner_q <= OWN_REQ;
            req_q   <= 1'b0;
        end else begin
            req_q <= handoff;
            if (handoff) begin
                owner_q <= OWN_RSP;
            end else if (rel_take) begin
                owner_q <= OWN_REQ;
            end
        end
    end

    assign owner     = owner_q;
    assign req_pulse = req_q;

endmodule

// File: rtl/mbox_regfile.sv
// Module: mailbox word storage.
// One register per word. The last word keeps only its low bits, because its
// top bit is shown from the ownership flag at read time.
// Assumes: write enables come already gated by ownership. On the last word,
// release outranks a responder write, which outranks a requester write.
module mbox_regfile #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int LAST   = WORDS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              vf_we,
    input  logic [ADDR_W-1:0] vf_addr,
    input  logic [DATA_W-1:0] vf_data,
    input  logic              pf_we,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic [DATA_W-1:0] pf_data,
    input  logic              rel_we,
    input  logic [DATA_W-1:0] rel_data,
    output logic [DATA_W-1:0] words [WORDS]
);

    logic [DATA_W-1:0] mem_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic vf_hit;
        logic pf_hit;
        logic rel_hit;

        // Per-word write select.
        always_comb begin
            vf_hit  = vf_we && (int'(vf_addr) == w);
            pf_hit  = pf_we && (int'(pf_addr) == w);
            rel_hit = rel_we && (w == LAST);
        end

        if (w == LAST) begin : g_last
            // Final word: top bit stays zero, release takes precedence.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    mem_q[w] <= '0;
                end else if (rel_hit) begin
                    mem_q[w] <= {1'b0, rel_data[DATA_W-2:0]};
                end else if (pf_hit) begin
                    mem_q[w] <= {1'b0, pf_data[DATA_W-2:0]};
                end else if (vf_hit) begin
                    mem_q[w] <= {1'b0, vf_data[DATA_W-2:0]};
                end
            end
        end else begin : g_body
            // Payload word: whichever side currently may write.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    mem_q[w] <= '0;
                end else if (pf_hit) begin
                    mem_q[w] <= pf_data;
                end else if (vf_hit) begin
                    mem_q[w] <= vf_data;
                end
            end
        end

        assign words[w] = mem_q[w];
    end

endmodule

// File: rtl/mbox_rdport.sv
// Module: one read port of the mailbox.
// Selects a word, inserts the owner flag as the top bit of the last word,
// and returns all ones while the function reset is held.
// Assumes: purely combinational; the address is stable for the sample.
module mbox_rdport
    import mbox_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int LAST   = WORDS - 1
) (
    input  logic [DATA_W-1:0] words [WORDS],
    input  owner_e            owner,
    input  logic              fn_rst,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    // Word select with owner overlay and reset-read override.
    always_comb begin
        data = '0;
        if (fn_rst) begin
            data = '1;
        end else if (int'(addr) == LAST) begin
            data = {owner == OWN_RSP, words[LAST][DATA_W-2:0]};
        end else if (int'(addr) < WORDS) begin
            data = words[addr];
        end
    end

endmodule

// File: rtl/mbox_aperture.sv
// Module: top of the shared mailbox with ownership handoff.
// Ties ownership control, word storage and two read ports together.
// Assumes: rst_n and fn_rst are synchronous to clk.
module mbox_aperture
    import mbox_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int LAST   = WORDS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fn_rst,
    input  logic              vf_wr_en,
    input  logic [ADDR_W-1:0] vf_wr_addr,
    input  logic [DATA_W-1:0] vf_wr_data,
    input  logic [ADDR_W-1:0] vf_rd_addr,
    output logic [DATA_W-1:0] vf_rd_data,
    input  logic              pf_wr_en,
    input  logic [ADDR_W-1:0] pf_wr_addr,
    input  logic [DATA_W-1:0] pf_wr_data,
    input  logic              pf_release,
    input  logic [DATA_W-1:0] pf_resp_word,
    input  logic [ADDR_W-1:0] pf_rd_addr,
    output logic [DATA_W-1:0] pf_rd_data,
    output logic              req_valid,
    output logic              pf_owns
);

    owner_e            owner;
    logic              vf_accept;
    logic              pf_accept;
    logic              rel_take;
    logic              vf_last;
    logic [DATA_W-1:0] words [WORDS];

    // Flags a requester write aimed at the final word.
    always_comb vf_last = is_last(int'(vf_wr_addr), WORDS);

    mbox_owner u_owner (
        .clk        (clk),
        .rst_n      (rst_n),
        .fn_rst     (fn_rst),
        .vf_wr_en   (vf_wr_en),
        .vf_wr_last (vf_last),
        .pf_wr_en   (pf_wr_en),
        .pf_release (pf_release),
        .owner      (owner),
        .vf_accept  (vf_accept),
        .pf_accept  (pf_accept),
        .rel_take   (rel_take),
        .req_pulse  (req_valid)
    );

    mbox_regfile #(.WORDS(WORDS), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (fn_rst),
        .vf_we    (vf_accept),
        .vf_addr  (vf_wr_addr),
        .vf_data  (vf_wr_data),
        .pf_we    (pf_accept),
        .pf_addr  (pf_wr_addr),
        .pf_data  (pf_wr_data),
        .rel_we   (rel_take),
        .rel_data (pf_resp_word),
        .words    (words)
    );

    mbox_rdport #(.WORDS(WORDS), .DATA_W(DATA_W)) u_vf_rd (
        .words  (words),
        .owner  (owner),
        .fn_rst (fn_rst),
        .addr   (vf_rd_addr),
        .data   (vf_rd_data)
    );

    mbox_rdport #(.WORDS(WORDS), .DATA_W(DATA_W)) u_pf_rd (
        .words  (words),
        .owner  (owner),
        .fn_rst (fn_rst),
        .addr   (pf_rd_addr),
        .data   (pf_rd_data)
    );

    assign pf_owns = (owner == OWN_RSP);

endmodule

// File: rtl/mbox_aperture_chk.sv
// Module: port-level properties of the mailbox, bound to the top module.
// Assumes: the sampled signals are the top module's own ports.
module mbox_aperture_chk #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int LAST   = WORDS - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fn_rst,
    input logic              vf_wr_en,
    input logic [ADDR_W-1:0] vf_wr_addr,
    input logic              pf_release,
    input logic [DATA_W-1:0] vf_rd_data,
    input logic [DATA_W-1:0] pf_rd_data,
    input logic              req_valid,
    input logic              pf_owns
);

    a_r3_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        (!pf_owns && !fn_rst && vf_wr_en && int'(vf_wr_addr) == LAST) |=> pf_owns);

    a_r4_pulse_with_owner: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> pf_owns);

    a_r4_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_owns) |-> req_valid);

    a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    a_r5_rsp_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_owns && !fn_rst && !pf_release) |=> pf_owns);

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_owns && !fn_rst && pf_release) |=> !pf_owns);

    a_r7_release_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!pf_owns && !(vf_wr_en && int'(vf_wr_addr) == LAST)) |=> !pf_owns);

    a_r8_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        fn_rst |-> (vf_rd_data == '1 && pf_rd_data == '1));

    a_r9_exit_req_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fn_rst) |-> (!pf_owns && !req_valid));

endmodule

bind mbox_aperture mbox_aperture_chk #(.WORDS(WORDS), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fn_rst     (fn_rst),
    .vf_wr_en   (vf_wr_en),
    .vf_wr_addr (vf_wr_addr),
    .pf_release (pf_release),
    .vf_rd_data (vf_rd_data),
    .pf_rd_data (pf_rd_data),
    .req_valid  (req_valid),
    .pf_owns    (pf_owns)
);

// File: tb/mbox_aperture_bench.sv
// Bench: scoreboard for the mailbox. Driver tasks push expected items; a
// monitor pops each item at the following falling edge and compares it.
module mbox_aperture_bench;

    localparam int K_VF_RD = 0;
    localparam int K_PF_RD = 1;
    localparam int K_REQ   = 2;
    localparam int K_OWNS  = 3;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fn_rst = 1'b0;
    logic        vf_wr_en = 1'b0;
    logic [2:0]  vf_wr_addr = '0;
    logic [31:0] vf_wr_data = '0;
    logic [2:0]  vf_rd_addr = '0;
    logic [31:0] vf_rd_data;
    logic        pf_wr_en = 1'b0;
    logic [2:0]  pf_wr_addr = '0;
    logic [31:0] pf_wr_data = '0;
    logic        pf_release = 1'b0;
    logic [31:0] pf_resp_word = '0;
    logic [2:0]  pf_rd_addr = '0;
    logic [31:0] pf_rd_data;
    logic        req_valid;
    logic        pf_owns;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #10 clk = ~clk;

    mbox_aperture u_mbox_aperture (
        .clk(clk), .rst_n(rst_n), .fn_rst(fn_rst),
        .vf_wr_en(vf_wr_en), .vf_wr_addr(vf_wr_addr), .vf_wr_data(vf_wr_data),
        .vf_rd_addr(vf_rd_addr), .vf_rd_data(vf_rd_data),
        .pf_wr_en(pf_wr_en), .pf_wr_addr(pf_wr_addr), .pf_wr_data(pf_wr_data),
        .pf_release(pf_release), .pf_resp_word(pf_resp_word),
        .pf_rd_addr(pf_rd_addr), .pf_rd_data(pf_rd_data),
        .req_valid(req_valid), .pf_owns(pf_owns)
    );

    // Monitor: compare one queued item at each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_VF_RD: act = vf_rd_data;
                    K_PF_RD: act = pf_rd_data;
                    K_REQ:   act = {31'd0, req_valid};
                    default: act = {31'd0, pf_owns};
                endcase
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Advance to just after the next rising edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Queue one expectation and let the monitor sample it.
    task automatic expect_item(input int kind, input logic [2:0] addr,
                               input logic [31:0] exp, input string tag);
        item_t it;
        if (kind == K_VF_RD) vf_rd_addr = addr;
        if (kind == K_PF_RD) pf_rd_addr = addr;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic vf_wr(input logic [2:0] a, input logic [31:0] d);
        vf_wr_en = 1'b1; vf_wr_addr = a; vf_wr_data = d;
        step();
        vf_wr_en = 1'b0;
    endtask

    task automatic pf_wr(input logic [2:0] a, input logic [31:0] d);
        pf_wr_en = 1'b1; pf_wr_addr = a; pf_wr_data = d;
        step();
        pf_wr_en = 1'b0;
    endtask

    task automatic pf_rel(input logic [31:0] r);
        pf_release = 1'b1; pf_resp_word = r;
        step();
        pf_release = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Driver: stimulus sequence.
    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1: reset state.
        for (int w = 0; w < 8; w++) expect_item(K_VF_RD, 3'(w), 32'h0, "R1 reset word");
        expect_item(K_OWNS, 3'd0, 32'd0, "R1 owner");
        expect_item(K_REQ, 3'd0, 32'd0, "R1 req");

        // R2: requester payload writes.
        vf_wr(3'd0, 32'hA5A5_0001);
        vf_wr(3'd3, 32'h1234_5678);
        expect_item(K_VF_RD, 3'd0, 32'hA5A5_0001, "R2 word0");
        expect_item(K_PF_RD, 3'd3, 32'h1234_5678, "R2 word3");

        // R6: responder write ignored while the requester owns.
        pf_wr(3'd2, 32'hDEAD_BEEF);
        expect_item(K_VF_RD, 3'd2, 32'h0, "R6 pf write ignored");

        // R7: release ignored while the requester owns.
        pf_rel(32'h0000_00FF);
        expect_item(K_OWNS, 3'd0, 32'd0, "R7 stray release owner");
        expect_item(K_VF_RD, 3'd7, 32'h0, "R7 stray release word7");

        // R3, R4: handoff and request pulse.
        vf_wr(3'd7, 32'h0100_0001);
        expect_item(K_REQ, 3'd0, 32'd1, "R4 pulse high");
        expect_item(K_REQ, 3'd0, 32'd0, "R4 pulse one cycle");
        expect_item(K_OWNS, 3'd0, 32'd1, "R3 owner rsp");
        expect_item(K_VF_RD, 3'd7, 32'h8100_0001, "R3 word7 owner bit");

        // R5: requester writes ignored while the responder owns.
        vf_wr(3'd1, 32'h5555_5555);
        expect_item(K_PF_RD, 3'd1, 32'h0, "R5 word1 unchanged");
        vf_wr(3'd7, 32'h0000_0055);
        expect_item(K_REQ, 3'd0, 32'd0, "R5 no second pulse");
        expect_item(K_PF_RD, 3'd7, 32'h8100_0001, "R5 word7 unchanged");

        // R6: responder write accepted while the responder owns.
        pf_wr(3'd4, 32'hCAFE_F00D);
        expect_item(K_VF_RD, 3'd4, 32'hCAFE_F00D, "R6 pf write stored");

        // R10: release beats a same-cycle responder write to word 7.
        pf_wr_en = 1'b1; pf_wr_addr = 3'd7; pf_wr_data = 32'h0000_7777;
        pf_release = 1'b1; pf_resp_word = 32'h0000_0181;
        step();
        pf_wr_en = 1'b0; pf_release = 1'b0;
        expect_item(K_OWNS, 3'd0, 32'd0, "R10 owner back");
        expect_item(K_VF_RD, 3'd7, 32'h0000_0181, "R10 response wins");

        // R7: plain release, bit 31 of the response not stored.
        vf_wr(3'd7, 32'h0000_0002);
        expect_item(K_OWNS, 3'd0, 32'd1, "R7 owned before release");
        pf_rel(32'h8000_0102);
        expect_item(K_OWNS, 3'd0, 32'd0, "R7 owner after release");
        expect_item(K_VF_RD, 3'd7, 32'h0000_0102, "R7 response word");

        // R8: function reset reads all ones, writes ignored.
        vf_wr(3'd7, 32'h0000_0003);
        fn_rst = 1'b1;
        step();
        expect_item(K_VF_RD, 3'd0, 32'hFFFF_FFFF, "R8 vf word0 ones");
        expect_item(K_PF_RD, 3'd7, 32'hFFFF_FFFF, "R8 pf word7 ones");
        vf_wr(3'd5, 32'h0BAD_0BAD);
        vf_wr(3'd7, 32'h0000_0009);
        expect_item(K_REQ, 3'd0, 32'd0, "R8 no pulse in reset");
        expect_item(K_OWNS, 3'd0, 32'd0, "R8 owner held");
        fn_rst = 1'b0;

        // R9: exit clears everything.
        expect_item(K_VF_RD, 3'd0, 32'h0, "R9 word0 cleared");
        expect_item(K_VF_RD, 3'd4, 32'h0, "R9 word4 cleared");
        expect_item(K_PF_RD, 3'd5, 32'h0, "R9 word5 no write");
        expect_item(K_VF_RD, 3'd7, 32'h0, "R9 word7 cleared");

        // R3: lone write to word 7 after the clear.
        vf_wr(3'd7, 32'h0000_0001);
        expect_item(K_REQ, 3'd0, 32'd1, "R3 lone write pulse");
        expect_item(K_PF_RD, 3'd7, 32'h8000_0001, "R3 lone write word7");

        step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule